// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block models, in synthesizable form, a serial EEPROM that holds 16-bit words. It is used as a target behind a chip-select/serial-clock/data-in/data-out bus. The host raises chip select and clocks in a command. A command is a start bit, a two-bit command code, an address field and, for the two pattern-loading commands, a 16-bit data word. A read then streams one word back on the data output. A programming command stays pending until chip select drops. That falling edge starts a self-timed busy period. While it runs, the host may reselect the target to watch a ready/busy level on the data output.

A write-enable latch gates every command that changes the array. The latch is clear after reset and is set and cleared by extended commands. The word storage is a register file. The address width is a parameter, 6 bits for 64 words or 8 bits for 256 words. The busy period is a parameter counted in system clock cycles. The serial clock and chip select are sampled on the system clock, and the serial clock must be slower than the system clock.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset, the data output is not driven (`dout_en` = 0, `dout` = 0), every stored word reads 16'hFFFF, and the write-enable latch is clear, so a write sent before any enable command changes nothing.
- R2: While chip select is high, data-in is sampled on each serial clock rising edge. Zeros before the first 1 are ignored. That 1 is the start bit. It is followed by two command-code bits and then the address, most significant bit first.
- R3: Command code 10 reads. After the last address bit, `dout` shows a dummy 0, and each following serial clock rising edge presents the next bit of the word, bit 15 first. A read works with the latch set or clear.
- R4: Command code 01 is followed by 16 data bits, MSB first. The word is stored only when chip select falls after the last data bit, and only if the latch is set.
- R5: Command code 00 takes its meaning from the two top address bits: 11 sets the latch, 00 clears it, 10 is erase-all and 01 is write-all. The lower address bits are ignored.
- R6: Command code 11 sets the addressed word to 16'hFFFF when the latch is set.
- R7: Erase-all sets every word to 16'hFFFF. Write-all, followed by 16 data bits, stores that pattern in every word. Both require the latch to be set.
- R8: Once the latch has been cleared, write, erase, erase-all and write-all leave the array unchanged.
- R9: A serial clock rising edge after the final bit of a programming command, before chip select falls, cancels that command.
- R10: An accepted programming command keeps the target busy for PROG_CYCLES system clocks. When chip select is raised again, `dout` is driven 0 while busy and 1 once ready.
- R11: While busy, start bits are ignored, and the ready/busy level stays on `dout`.
- R12: Whenever chip select is low, `dout_en` and `dout` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data or ready/busy level to the host |
| dout_en | output | 1 | High when `dout` is driven |

## Verification
The assertions assume that `cs` and `sk` are already synchronous to `clk`, and that each serial clock level lasts at least one system clock. Edge detection then never misses or doubles a serial edge. They also assume that chip select falls only while the serial clock is low, so a deselect is never mistaken for an extra clock edge. The stimulus changes all inputs on the falling edge of the system clock. It holds each serial clock phase for two system clocks and lowers chip select together with, or after, the serial clock.

// File: rtl/seep_pkg.sv
package seep_pkg;

   typedef enum logic [2:0] {
      FS_START,
      FS_CODE,
      FS_ADDR,
      FS_DATA,
      FS_READ,
      FS_ARMED,
      FS_VOID
   } fs_t;

   typedef enum logic [2:0] {
      CM_NONE,
      CM_READ,
      CM_WRITE,
      CM_ERASE,
      CM_ERASE_ALL,
      CM_WRITE_ALL,
      CM_LATCH_ON,
      CM_LATCH_OFF
   } cmd_t;

   function automatic cmd_t seep_decode(input logic [1:0] code, input logic [1:0] sub);
      cmd_t c;
      case (code)
         2'b10:   c = CM_READ;
         2'b01:   c = CM_WRITE;
         2'b11:   c = CM_ERASE;
         default: begin
            case (sub)
               2'b11:   c = CM_LATCH_ON;
               2'b10:   c = CM_ERASE_ALL;
               2'b01:   c = CM_WRITE_ALL;
               default: c = CM_LATCH_OFF;
            endcase
         end
      endcase
      return c;
   endfunction

   function automatic logic seep_has_data(input cmd_t c);
      return (c == CM_WRITE) || (c == CM_WRITE_ALL);
   endfunction

   function automatic logic seep_is_prog(input cmd_t c);
      return (c == CM_WRITE) || (c == CM_ERASE) ||
             (c == CM_ERASE_ALL) || (c == CM_WRITE_ALL);
   endfunction

endpackage

// File: rtl/seep_frontend.sv
module seep_frontend
   import seep_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          sk_rise,
   input  logic          di,
   input  logic          busy,
   input  logic [DW-1:0] rd_word,
   output logic [AW-1:0] rd_addr,
   output cmd_t          cmd,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          armed,
   output logic          idle,
   output logic          in_read,
   output logic          rd_bit,
   output logic          start_evt
);
   localparam int MAXF = (DW > AW) ? DW : AW;
   localparam int CW   = $clog2(MAXF + 1);

   fs_t           st_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]    code_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] out_sr_q;
   logic          rd_bit_q;
   cmd_t          cmd_q;
   logic [AW-1:0] nxt_addr;
   cmd_t          nxt_cmd;

   assign nxt_addr  = {addr_q[AW-2:0], di};
   assign nxt_cmd   = seep_decode(code_q, nxt_addr[AW-1:AW-2]);
   assign rd_addr   = nxt_addr;
   assign start_evt = cs && sk_rise && (st_q == FS_START) && di && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= FS_START;
         cnt_q    <= '0;
         code_q   <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         out_sr_q <= '0;
         rd_bit_q <= 1'b0;
         cmd_q    <= CM_NONE;
      end else if (!cs) begin
         st_q     <= FS_START;
         cnt_q    <= '0;
         rd_bit_q <= 1'b0;
      end else if (sk_rise) begin
         case (st_q)
            FS_START: begin
               if (start_evt) begin
                  st_q  <= FS_CODE;
                  cnt_q <= '0;
               end
            end
            FS_CODE: begin
               code_q <= {code_q[0], di};
               if (cnt_q == CW'(1)) begin
                  st_q  <= FS_ADDR;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_ADDR: begin
               addr_q <= nxt_addr;
               if (cnt_q == CW'(AW - 1)) begin
                  cnt_q <= '0;
                  cmd_q <= nxt_cmd;
                  if (nxt_cmd == CM_READ) begin
                     st_q     <= FS_READ;
                     out_sr_q <= rd_word;
                     rd_bit_q <= 1'b0;
                  end else if (seep_has_data(nxt_cmd)) begin
                     st_q <= FS_DATA;
                  end else begin
                     st_q <= FS_ARMED;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_DATA: begin
               data_q <= {data_q[DW-2:0], di};
               if (cnt_q == CW'(DW - 1)) begin
                  st_q  <= FS_ARMED;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_READ: begin
               rd_bit_q <= out_sr_q[DW-1];
               out_sr_q <= {out_sr_q[DW-2:0], 1'b0};
            end
            FS_ARMED: st_q <= FS_VOID;
            default:  st_q <= FS_VOID;
         endcase
      end
   end

   assign cmd      = cmd_q;
   assign cmd_addr = addr_q;
   assign cmd_data = data_q;
   assign armed    = (st_q == FS_ARMED);
   assign idle     = (st_q == FS_START);
   assign in_read  = (st_q == FS_READ);
   assign rd_bit   = rd_bit_q;

endmodule

// File: rtl/seep_array.sv
module seep_array
   import seep_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  cmd_t          cmd,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_word
);
   localparam int NW = 1 << AW;

   logic [DW-1:0] words [NW];

   for (genvar i = 0; i < NW; i++) begin : g_word
      logic [DW-1:0] w_q;
      logic          hit;
      assign hit = (wr_addr == AW'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            w_q <= '1;
         end else if (go) begin
            case (cmd)
               CM_WRITE:     if (hit) w_q <= wr_data;
               CM_ERASE:     if (hit) w_q <= '1;
               CM_ERASE_ALL: w_q <= '1;
               CM_WRITE_ALL: w_q <= wr_data;
               default:      w_q <= w_q;
            endcase
         end
      end
      assign words[i] = w_q;
   end

   assign rd_word = words[rd_addr];

endmodule

// File: rtl/seep_timer.sv
module seep_timer #(
   parameter int PROG_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(PROG_CYCLES + 1);

   logic [TW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           left_q <= '0;
      else if (start)       left_q <= TW'(PROG_CYCLES);
      else if (left_q != 0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
   import seep_pkg::*;
#(
   parameter int ADDR_BITS   = 6,
   parameter int WORD_BITS   = 16,
   parameter int PROG_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic dout,
   output logic dout_en
);
   initial begin : param_check
      assert (ADDR_BITS == 6 || ADDR_BITS == 8)
         else $fatal(1, "ADDR_BITS must be 6 or 8");
      assert (WORD_BITS == 16)
         else $fatal(1, "WORD_BITS must be 16");
      assert (PROG_CYCLES >= 1)
         else $fatal(1, "PROG_CYCLES must be at least 1");
   end

   logic                 cs_q, sk_q;
   logic                 sk_rise, cs_fall;
   logic                 busy, wen_q, stat_q;
   logic                 launch, prog_go;
   cmd_t                 cmd;
   logic [ADDR_BITS-1:0] rd_addr, cmd_addr;
   logic [WORD_BITS-1:0] cmd_data, rd_word;
   logic                 armed, idle, in_read, rd_bit, start_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         sk_q <= 1'b0;
      end else begin
         cs_q <= cs;
         sk_q <= sk;
      end
   end

   assign sk_rise = cs && sk && !sk_q;
   assign cs_fall = cs_q && !cs;
   assign launch  = cs_fall && armed && !busy;
   assign prog_go = launch && wen_q && seep_is_prog(cmd);

   seep_frontend #(.AW(ADDR_BITS), .DW(WORD_BITS)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .sk_rise  (sk_rise),
      .di       (di),
      .busy     (busy),
      .rd_word  (rd_word),
      .rd_addr  (rd_addr),
      .cmd      (cmd),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .armed    (armed),
      .idle     (idle),
      .in_read  (in_read),
      .rd_bit   (rd_bit),
      .start_evt(start_evt)
   );

   seep_array #(.AW(ADDR_BITS), .DW(WORD_BITS)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (prog_go),
      .cmd    (cmd),
      .wr_addr(cmd_addr),
      .wr_data(cmd_data),
      .rd_addr(rd_addr),
      .rd_word(rd_word)
   );

   seep_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(prog_go),
      .busy (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wen_q  <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (launch && cmd == CM_LATCH_ON)  wen_q <= 1'b1;
         if (launch && cmd == CM_LATCH_OFF) wen_q <= 1'b0;
         if (prog_go)        stat_q <= 1'b1;
         else if (start_evt) stat_q <= 1'b0;
      end
   end

   assign dout_en = cs && (in_read || (stat_q && idle));
   assign dout    = dout_en && (in_read ? rd_bit : !busy);

endmodule

// File: rtl/seep_chk.sv
module seep_chk #(
   parameter int PROG_CYCLES = 20
) (
   input logic clk,
   input logic rst_n,
   input logic cs,
   input logic dout,
   input logic dout_en,
   input logic busy,
   input logic wen_q
);
   int busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> (!dout_en && !dout)); // R12

   AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wen_q); // R8

   AST_PROG_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!$past(cs) && $past(cs, 2))); // R4

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == PROG_CYCLES)); // R10

   AST_LATCH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wen_q)); // R11

endmodule

bind serial_eeprom_target seep_chk #(.PROG_CYCLES(PROG_CYCLES)) u_seep_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs     (cs),
   .dout   (dout),
   .dout_en(dout_en),
   .busy   (busy),
   .wen_q  (wen_q)
);

// File: tb/serial_eeprom_target_test.sv
module serial_eeprom_target_test;
   localparam int AWT  = 6;
   localparam int PROG = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic dout, dout_en;
   int   checks = 0;
   int   errors = 0;

   logic [15:0] mem [64];
   bit          wen = 1'b0;

   always #2 clk = ~clk;

   serial_eeprom_target #(.ADDR_BITS(AWT), .WORD_BITS(16), .PROG_CYCLES(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // R12 compared on every clock while deselected
   always @(negedge clk) begin
      if (rst_n && !cs)
         chk(!dout_en && !dout, "R12", {30'd0, dout_en, dout}, 32'd0);
   end

   task automatic send_bit(input bit b);
      @(negedge clk);
      di = b; sk = 1'b0;
      repeat (2) @(negedge clk);
      sk = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic select_t();
      @(negedge clk);
      sk = 1'b0; cs = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic deselect_t();
      @(negedge clk);
      sk = 1'b0; cs = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [1:0] code, input logic [AWT-1:0] a);
      send_bit(1'b1);
      send_bit(code[1]); send_bit(code[0]);
      for (int i = AWT - 1; i >= 0; i--) send_bit(a[i]);
   endtask

   task automatic do_read(input logic [AWT-1:0] a, input int lead, input string req);
      logic [15:0] got;
      bit          dummy_ok;
      select_t();
      for (int i = 0; i < lead; i++) send_bit(1'b0);
      send_hdr(2'b10, a);
      dummy_ok = dout_en && !dout;
      got = '0;
      for (int i = 0; i < 16; i++) begin
         send_bit(1'b0);
         got = {got[14:0], dout};
      end
      chk(dummy_ok, {req, " dummy"}, {31'd0, dummy_ok}, 32'd1);
      chk(got == mem[a], req, {16'd0, got}, {16'd0, mem[a]});
      deselect_t();
   endtask

   // programming / extended command; extra=1 adds a cancelling clock edge (R9)
   task automatic do_cmd(input logic [1:0] code, input logic [AWT-1:0] a,
                         input logic [15:0] d, input bit extra, input string req);
      bit has_d, prog, go;
      has_d = (code == 2'b01) || (code == 2'b00 && a[AWT-1:AWT-2] == 2'b01);
      prog  = (code != 2'b00) || (a[AWT-1:AWT-2] inside {2'b10, 2'b01});
      go    = !extra;
      select_t();
      send_hdr(code, a);
      if (has_d) for (int i = 15; i >= 0; i--) send_bit(d[i]);
      if (extra) send_bit(1'b0);
      deselect_t();
      if (go && code == 2'b00 && a[AWT-1:AWT-2] == 2'b11) wen = 1'b1;
      if (go && code == 2'b00 && a[AWT-1:AWT-2] == 2'b00) wen = 1'b0;
      if (prog) begin
         bit launched;
         launched = go && wen;
         if (launched) begin
            case (code)
               2'b01: mem[a] = d;
               2'b11: mem[a] = 16'hFFFF;
               default: for (int k = 0; k < 64; k++)
                  mem[k] = (a[AWT-1:AWT-2] == 2'b10) ? 16'hFFFF : d;
            endcase
         end
         select_t();
         if (launched) begin
            chk(dout_en && !dout, "R10 busy level", {30'd0, dout_en, dout}, 32'd2);
            repeat (PROG + 4) @(negedge clk);
            chk(dout_en && dout, "R10 ready level", {30'd0, dout_en, dout}, 32'd3);
         end else begin
            chk(!dout_en, {req, " no launch"}, {31'd0, dout_en}, 32'd0);
         end
         deselect_t();
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < 64; k++) mem[k] = 16'hFFFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dout_en && !dout, "R1 reset outputs", {30'd0, dout_en, dout}, 32'd0);

      do_cmd(2'b01, 6'd5, 16'h1111, 1'b0, "R1");        // latch clear after reset
      do_read(6'd5, 0, "R1");
      do_cmd(2'b00, 6'b110000, 16'h0, 1'b0, "R5");      // latch on
      do_cmd(2'b01, 6'd5, 16'hA5C3, 1'b0, "R4");
      do_read(6'd5, 0, "R4");
      do_cmd(2'b01, 6'd63, 16'h1234, 1'b0, "R4");
      do_read(6'd63, 0, "R3");
      do_read(6'd63, 2, "R2");                          // leading zeros
      do_cmd(2'b11, 6'd5, 16'h0, 1'b0, "R6");
      do_read(6'd5, 0, "R6");
      do_cmd(2'b00, 6'b011010, 16'h0F0F, 1'b0, "R7");   // write all, low bits random
      do_read(6'd0, 0, "R7");
      do_read(6'd40, 0, "R7");
      do_cmd(2'b00, 6'b100101, 16'h0, 1'b0, "R7");      // erase all
      do_read(6'd17, 0, "R7");
      do_cmd(2'b01, 6'd9, 16'hBEEF, 1'b0, "R4");
      do_cmd(2'b01, 6'd9, 16'h0000, 1'b1, "R9");        // cancelled
      do_read(6'd9, 0, "R9");

      // R11: start bits ignored while busy
      select_t();
      send_hdr(2'b01, 6'd12);
      for (int i = 15; i >= 0; i--) send_bit(((16'h5555 >> i) & 1) != 0);
      deselect_t();
      mem[12] = 16'h5555;
      select_t();
      send_bit(1'b1); send_bit(1'b0);
      chk(dout_en && !dout, "R11 status kept", {30'd0, dout_en, dout}, 32'd2);
      repeat (PROG + 4) @(negedge clk);
      chk(dout_en && dout, "R11 ready", {30'd0, dout_en, dout}, 32'd3);
      deselect_t();
      do_read(6'd12, 0, "R11");

      do_cmd(2'b00, 6'b001111, 16'h0, 1'b0, "R5");      // latch off
      do_cmd(2'b01, 6'd12, 16'h0000, 1'b0, "R8");
      do_cmd(2'b00, 6'b100000, 16'h0, 1'b0, "R8");
      do_read(6'd12, 0, "R8");
      do_read(6'd63, 0, "R3");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule